// File: doc/BRIEF.md
# Prefix-extended immediate builder

This block sits in the decode stage of a processor. It turns the short immediate field of an instruction into the final 24-bit operand. Instructions carry either a 7-bit or a 13-bit immediate. Up to two extension-prefix instructions that come just before an instruction can widen that immediate. Each prefix carries a 13-bit field.

The block keeps the pending prefix fields and a prefix count. When a real instruction arrives, it combines the fields with the instruction's own immediate and presents the result one cycle later. It then forgets every prefix. Where the sign bit of the result comes from depends on how many prefixes were pending. With no prefix, the immediate's own top bit is the sign for the signed kinds. With prefixes, the top bit of the widened value is the sign, and the immediate's top bit is plain data.

Prefixes cannot apply to an instruction in a branch delay slot. A taken interrupt discards anything pending. More than two prefixes in a row keep only the newest two and raise a one-cycle diagnostic pulse.

Top module: `ext_imm_builder`

## Requirements
- R1: After reset, imm_valid and pfx_overflow are 0 and no prefix is pending, so the first instruction is built as if it had no prefix.
- R2: With no prefix pending, the kind codes are 0 = unsigned 7-bit (imm_field[6:0]), 1 = signed 7-bit, 2 = unsigned 13-bit (imm_field[12:0]) and 3 = signed 13-bit. The unsigned kinds are zero-extended to 24 bits. The signed kinds are sign-extended from their top bit; for example, signed 7-bit 0x7e gives 0xfffffe.
- R3: With one prefix P pending and a 7-bit kind (0 or 1), the result is {P, imm[6:0]} (20 bits), sign-extended from P[12] to 24 bits. For example, P = 0x1ff with imm 0x7f gives 0x00ffff.
- R4: With one prefix P pending and a 13-bit kind (2 or 3), the result is the 16-bit value {P[2:0], imm[12:0]}, sign-extended from P[2] to 24 bits.
- R5: With two prefixes pending (older A, newer B), the result is the low 24 bits of {A, B, imm} for either kind. That is {A[3:0], B, imm[6:0]} for the 7-bit kinds and {B[10:0], imm[12:0]} for the 13-bit kinds.
- R6: An accepted instruction (insn_valid high, irq_taken low) raises imm_valid for exactly one cycle, in the cycle after the strobe, with imm_value holding the result. The prefix state is then empty, so the next instruction sees only prefixes that arrive after it.
- R7: An instruction with in_delay_slot high is built as if no prefix were pending (R2), and any pending prefixes are discarded.
- R8: In a cycle with irq_taken high, all pending prefixes are discarded, and any instruction or prefix strobe in that same cycle is dropped: no imm_valid follows it.
- R9: A prefix that arrives while two are pending discards the oldest, keeps the count at two and raises pfx_overflow for one cycle in the following cycle.
- R10: A prefix strobe in the same cycle as an accepted instruction is ignored; it does not apply to that instruction or to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | A real (non-prefix) instruction is decoded this cycle |
| imm_field | input | 13 | Immediate field of that instruction |
| imm_kind | input | 2 | Immediate kind, encoded as in R2 |
| in_delay_slot | input | 1 | The instruction sits in a branch delay slot |
| pfx_valid | input | 1 | An extension prefix is decoded this cycle |
| pfx_field | input | 13 | 13-bit field of the prefix |
| irq_taken | input | 1 | An interrupt is taken this cycle |
| imm_valid | output | 1 | One-cycle pulse: imm_value holds a new result |
| imm_value | output | 24 | Built immediate |
| pfx_overflow | output | 1 | One-cycle pulse after a third consecutive prefix |

## Verification
The hardest states to reach are those where the stored prefixes and the strobes that should discard them meet. Examples are a full prefix store that then takes a third and a fourth prefix, and an interrupt or a delay-slot instruction that lands while two prefixes are pending. The stimulus builds these on purpose: it loads two prefixes, then overflows the store, then sends an instruction whose result shows which two fields survived. Separate runs put an interrupt, a delay slot or a same-cycle prefix against a loaded store, and the next instruction's result shows whether the store was emptied.

// File: rtl/ext_imm_pkg.sv
// Shared definitions for the prefix-extended immediate builder.
// Assumes the kind encoding is fixed by the decoder that feeds the block.
package ext_imm_pkg;
    typedef enum logic [1:0] {
        KIND_U7  = 2'd0,
        KIND_S7  = 2'd1,
        KIND_U13 = 2'd2,
        KIND_S13 = 2'd3
    } imm_kind_e;

    typedef logic [1:0] pfx_cnt_t;
endpackage

// File: rtl/ext_pfx_store.sv
// Holds up to two pending prefix fields and their count.
// Assumes an accepted instruction or a taken interrupt empties the store,
// and that a prefix strobe is ignored in the same cycle as either of them.
module ext_pfx_store
    import ext_imm_pkg::*;
#(
    parameter int PFX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfx_stb,
    input  logic             clear,
    input  logic [PFX_W-1:0] pfx_in,
    output pfx_cnt_t         cnt,
    output logic [PFX_W-1:0] old_f,
    output logic [PFX_W-1:0] new_f,
    output logic             ovf
);
    localparam pfx_cnt_t FULL = 2'd2;

    logic accept;
    assign accept = pfx_stb && !clear;

    // Update the count and the fields; a third prefix shifts out the oldest
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt   <= '0;
            old_f <= '0;
            new_f <= '0;
        end else if (accept) begin
            case (cnt)
                2'd0: begin
                    old_f <= pfx_in;
                    cnt   <= 2'd1;
                end
                2'd1: begin
                    new_f <= pfx_in;
                    cnt   <= FULL;
                end
                default: begin
                    old_f <= new_f;
                    new_f <= pfx_in;
                end
            endcase
        end
    end

    // Pulse the diagnostic flag one cycle after a prefix hits a full store
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= accept && (cnt == FULL);
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);
    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == 2'd0));
    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(cnt) == FULL && $past(pfx_stb)));
    // R9
    full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && pfx_stb && !clear) |=> (cnt == FULL && old_f == $past(new_f)));
endmodule

// File: rtl/ext_imm_compose.sv
// Combinational builder of the wide immediate from the immediate field,
// its kind and zero, one or two prefix fields.
// Assumes the caller forces the count to zero for delay-slot instructions.
module ext_imm_compose
    import ext_imm_pkg::*;
#(
    parameter int PFX_W   = 13,
    parameter int SHORT_W = 7,
    parameter int LONG_W  = 13,
    parameter int MID_W   = 16,
    parameter int IMM_W   = 24
) (
    input  logic [1:0]        kind,
    input  logic [LONG_W-1:0] imm,
    input  pfx_cnt_t          n,
    input  logic [PFX_W-1:0]  a,
    input  logic [PFX_W-1:0]  b,
    output logic [IMM_W-1:0]  value
);
    localparam int ONE_S_W = PFX_W + SHORT_W;
    localparam int LOW_A_W = MID_W - LONG_W;
    localparam int TWO_S_W = 2 * PFX_W + SHORT_W;
    localparam int TWO_L_W = 2 * PFX_W + LONG_W;

    imm_kind_e             k;
    logic                  is_short;
    logic                  is_signed;
    logic [SHORT_W-1:0]    s_imm;
    logic [ONE_S_W-1:0]    one_s;
    logic [MID_W-1:0]      one_l;
    logic [TWO_S_W-1:0]    two_s;
    logic [TWO_L_W-1:0]    two_l;

    assign k         = imm_kind_e'(kind);
    assign is_short  = (k == KIND_U7) || (k == KIND_S7);
    assign is_signed = (k == KIND_S7) || (k == KIND_S13);
    assign s_imm     = imm[SHORT_W-1:0];
    assign one_s     = {a, s_imm};
    assign one_l     = {a[LOW_A_W-1:0], imm};
    assign two_s     = {a, b, s_imm};
    assign two_l     = {a, b, imm};

    // Pick the widening rule from the prefix count and the immediate size
    always_comb begin
        case (n)
            2'd0: begin
                if (is_short)
                    value = is_signed ? IMM_W'($signed(s_imm)) : IMM_W'(s_imm);
                else
                    value = is_signed ? IMM_W'($signed(imm)) : IMM_W'(imm);
            end
            2'd1: value = is_short ? IMM_W'($signed(one_s)) : IMM_W'($signed(one_l));
            default: value = is_short ? IMM_W'(two_s) : IMM_W'(two_l);
        endcase
    end
endmodule

// File: rtl/ext_imm_builder.sv
// Top of the prefix-extended immediate builder. Collects prefixes and
// registers the built immediate one cycle after each accepted instruction.
// Assumes at most one instruction per cycle, and that irq_taken marks a
// cycle whose decode is abandoned.
module ext_imm_builder
    import ext_imm_pkg::*;
#(
    parameter int PFX_W   = 13,
    parameter int SHORT_W = 7,
    parameter int LONG_W  = 13,
    parameter int MID_W   = 16,
    parameter int IMM_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [LONG_W-1:0] imm_field,
    input  logic [1:0]        imm_kind,
    input  logic              in_delay_slot,
    input  logic              pfx_valid,
    input  logic [PFX_W-1:0]  pfx_field,
    input  logic              irq_taken,
    output logic              imm_valid,
    output logic [IMM_W-1:0]  imm_value,
    output logic              pfx_overflow
);
    logic             fire;
    logic             flush;
    pfx_cnt_t         cnt;
    pfx_cnt_t         eff_cnt;
    logic [PFX_W-1:0] old_f;
    logic [PFX_W-1:0] new_f;
    logic [IMM_W-1:0] built;

    assign fire    = insn_valid && !irq_taken;
    assign flush   = insn_valid || irq_taken;
    assign eff_cnt = in_delay_slot ? 2'd0 : cnt;

    ext_pfx_store #(.PFX_W(PFX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pfx_stb (pfx_valid),
        .clear   (flush),
        .pfx_in  (pfx_field),
        .cnt     (cnt),
        .old_f   (old_f),
        .new_f   (new_f),
        .ovf     (pfx_overflow)
    );

    ext_imm_compose #(
        .PFX_W   (PFX_W),
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W),
        .MID_W   (MID_W),
        .IMM_W   (IMM_W)
    ) u_compose (
        .kind  (imm_kind),
        .imm   (imm_field),
        .n     (eff_cnt),
        .a     (old_f),
        .b     (new_f),
        .value (built)
    );

    // Register the result and its one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_valid <= 1'b0;
            imm_value <= '0;
        end else begin
            imm_valid <= fire;
            if (fire) imm_value <= built;
        end
    end

    // R6
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |-> $past(insn_valid));
    // R8
    irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !imm_valid);
    // R6
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable(imm_value));
    // R8
    irq_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (cnt == 2'd0));
endmodule

// File: tb/ext_imm_builder_test.sv
module ext_imm_builder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [12:0] imm_field = '0;
    logic [1:0]  imm_kind = '0;
    logic        in_delay_slot = 1'b0;
    logic        pfx_valid = 1'b0;
    logic [12:0] pfx_field = '0;
    logic        irq_taken = 1'b0;
    logic        imm_valid;
    logic [23:0] imm_value;
    logic        pfx_overflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    int          m_cnt = 0;
    logic [12:0] m_a = '0;
    logic [12:0] m_b = '0;

    always #2 clk = ~clk;

    ext_imm_builder uut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .imm_field(imm_field),
        .imm_kind(imm_kind), .in_delay_slot(in_delay_slot), .pfx_valid(pfx_valid),
        .pfx_field(pfx_field), .irq_taken(irq_taken), .imm_valid(imm_valid),
        .imm_value(imm_value), .pfx_overflow(pfx_overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected value computed from the requirements R2..R5
    function automatic logic [23:0] model(input logic [1:0] k, input logic [12:0] im,
                                          input int n, input logic [12:0] a,
                                          input logic [12:0] b);
        case (n)
            0: case (k)
                2'd0: return {17'b0, im[6:0]};
                2'd1: return {{17{im[6]}}, im[6:0]};
                2'd2: return {11'b0, im};
                default: return {{11{im[12]}}, im};
            endcase
            1: if (!k[1]) return {{4{a[12]}}, a, im[6:0]};
               else       return {{8{a[2]}}, a[2:0], im};
            default: if (!k[1]) return {a[3:0], b, im[6:0]};
                     else       return {b[10:0], im};
        endcase
    endfunction

    task automatic send_pfx(input logic [12:0] f, input string req);
        bit exp_ovf;
        exp_ovf = (m_cnt == 2);
        if (m_cnt == 0) begin m_a = f; m_cnt = 1; end
        else if (m_cnt == 1) begin m_b = f; m_cnt = 2; end
        else begin m_a = m_b; m_b = f; end
        pfx_valid = 1'b1;
        pfx_field = f;
        @(negedge clk);
        pfx_valid = 1'b0;
        check(pfx_overflow == exp_ovf, req, 32'(pfx_overflow), 32'(exp_ovf));
    endtask

    task automatic issue(input logic [1:0] k, input logic [12:0] im, input bit ds,
                         input bit with_pfx, input string req);
        exp_q.push_back(model(k, im, ds ? 0 : m_cnt, m_a, m_b));
        tag_q.push_back(req);
        m_cnt = 0;
        insn_valid = 1'b1;
        imm_kind = k;
        imm_field = im;
        in_delay_slot = ds;
        pfx_valid = with_pfx;
        pfx_field = 13'h1abc;
        @(negedge clk);
        insn_valid = 1'b0;
        in_delay_slot = 1'b0;
        pfx_valid = 1'b0;
    endtask

    task automatic irq_cycle(input bit with_insn, input bit with_pfx, input string req);
        m_cnt = 0;
        irq_taken = 1'b1;
        insn_valid = with_insn;
        imm_kind = 2'd1;
        imm_field = 13'h0055;
        pfx_valid = with_pfx;
        pfx_field = 13'h0777;
        @(negedge clk);
        irq_taken = 1'b0;
        insn_valid = 1'b0;
        pfx_valid = 1'b0;
        check(imm_valid == 1'b0, req, 32'(imm_valid), 32'd0);
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n && imm_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", 32'(imm_value), 32'd0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(imm_value == e, t, 32'(imm_value), 32'(e));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(imm_valid == 1'b0, "R1 valid after reset", 32'(imm_valid), 32'd0);
        check(pfx_overflow == 1'b0, "R1 overflow after reset", 32'(pfx_overflow), 32'd0);
        issue(2'd0, 13'h0033, 0, 0, "R1 first insn without prefix");

        // R2 no prefix, all kinds
        issue(2'd1, 13'h007e, 0, 0, "R2 signed7 0x7e");
        check(model(2'd1, 13'h007e, 0, 0, 0) == 24'hfffffe, "R2 model 0x7e",
              32'(model(2'd1, 13'h007e, 0, 0, 0)), 32'hfffffe);
        issue(2'd0, 13'h007e, 0, 0, "R2 unsigned7 0x7e");
        issue(2'd3, 13'h1000, 0, 0, "R2 signed13 0x1000");
        issue(2'd2, 13'h1000, 0, 0, "R2 unsigned13 0x1000");

        // R3 one prefix, 7-bit kinds
        send_pfx(13'h01ff, "R3 prefix no overflow");
        issue(2'd1, 13'h007f, 0, 0, "R3 0x1ff/0x7f");
        send_pfx(13'h1000, "R3 prefix no overflow");
        issue(2'd0, 13'h0005, 0, 0, "R3 negative prefix");

        // R4 one prefix, 13-bit kinds
        send_pfx(13'h0005, "R4 prefix no overflow");
        issue(2'd2, 13'h1abc, 0, 0, "R4 imm16 negative");
        send_pfx(13'h0003, "R4 prefix no overflow");
        issue(2'd3, 13'h1fff, 0, 0, "R4 imm16 positive");

        // R5 two prefixes
        send_pfx(13'h000a, "R5 prefix no overflow");
        send_pfx(13'h1234, "R5 prefix no overflow");
        issue(2'd1, 13'h0055, 0, 0, "R5 imm24 short");
        send_pfx(13'h1fff, "R5 prefix no overflow");
        send_pfx(13'h0421, "R5 prefix no overflow");
        issue(2'd2, 13'h0abc, 0, 0, "R5 imm24 long");

        // R6 state clears after consuming
        issue(2'd1, 13'h0040, 0, 0, "R6 no leftover prefix");

        // R7 delay slot ignores and clears prefixes
        send_pfx(13'h0fff, "R7 prefix no overflow");
        send_pfx(13'h0fff, "R7 prefix no overflow");
        issue(2'd1, 13'h0041, 1, 0, "R7 delay slot ignores prefixes");
        issue(2'd0, 13'h0041, 0, 0, "R7 prefixes gone after delay slot");

        // R8 interrupt discards pending state and same-cycle strobes
        send_pfx(13'h0123, "R8 prefix no overflow");
        irq_cycle(0, 0, "R8 irq alone no result");
        issue(2'd1, 13'h0070, 0, 0, "R8 prefix discarded by irq");
        send_pfx(13'h0123, "R8 prefix no overflow");
        irq_cycle(1, 0, "R8 insn with irq dropped");
        issue(2'd3, 13'h1800, 0, 0, "R8 state empty after irq+insn");
        irq_cycle(0, 1, "R8 prefix with irq dropped");
        issue(2'd0, 13'h0011, 0, 0, "R8 same-cycle prefix not kept");

        // R9 third and fourth prefix overflow
        send_pfx(13'h0001, "R9 first prefix");
        send_pfx(13'h0002, "R9 second prefix");
        send_pfx(13'h0a5b, "R9 third prefix flags overflow");
        send_pfx(13'h1c3d, "R9 fourth prefix flags overflow");
        @(negedge clk);
        check(pfx_overflow == 1'b0, "R9 overflow is one cycle", 32'(pfx_overflow), 32'd0);
        issue(2'd0, 13'h0066, 0, 0, "R9 newest two prefixes kept");

        // R10 prefix in same cycle as instruction is ignored
        issue(2'd1, 13'h0060, 0, 1, "R10 same-cycle prefix not applied");
        issue(2'd1, 13'h0060, 0, 0, "R10 same-cycle prefix not kept");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all results produced", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule